// File: doc/BRIEF.md
# Receive FIFO with Live Error Counts

This block buffers bytes coming out of a serial receiver before the host reads them. Each entry holds a data byte together with two flags from the receiver, one for a parity error and one for a framing error. The host sees the oldest entry at the head of the queue without waiting a cycle, and removes it with a pop request.

Alongside the storage, the block keeps two counts. One is the number of entries now in the queue that arrived with a parity error. The other is the same count for framing errors. Both counts are packed into a read-only 16-bit status word. Because each field is only six bits wide, a full queue of 64 bad bytes reads as 0 in that field. A separate summary flag therefore reports whether any stored entry is bad, so software checks that flag before it trusts the counts.

A push into a full queue is lost and sets a sticky overrun flag. A pop from an empty queue does nothing. A synchronous clear input empties the queue and zeroes both counts and the overrun flag.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty, the fill level is 0, and statusWord, rxErr and overrun are all 0.
- R2: Entries leave in the order they arrived. While the queue is not empty, headData, headParErr and headFrmErr show the oldest entry. fillLevel follows accepted pushes and pops, and fifoEmpty is high exactly when fillLevel is 0.
- R3: The queue holds 64 entries, and fifoFull is high at 64. A push while full is dropped, leaves the contents unchanged and sets overrun. overrun stays set until reset or fifoClear.
- R4: A pop request while the queue is empty is ignored and changes no output.
- R5: The parity count equals the number of stored entries whose parity flag is 1. It rises on an accepted push of such an entry and falls on a pop of one.
- R6: The framing count equals the number of stored entries whose framing flag is 1, with the same push and pop behaviour as R5.
- R7: On a cycle that accepts both a push and a pop, each count changes by the pushed flag minus the popped flag, so it can stay the same.
- R8: statusWord bits 13:8 carry the parity count modulo 64, bits 5:0 carry the framing count modulo 64, and bits 15:14 and 7:6 always read 0.
- R9: When all 64 stored entries carry an error of one kind, that field of statusWord reads 0 while rxErr stays 1.
- R10: rxErr is 1 exactly when at least one stored entry has its parity or framing flag set.
- R11: fifoClear, sampled on a clock edge, empties the queue, zeroes both counts and clears overrun. It takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoClear | input | 1 | Synchronous flush of the queue, the counts and overrun |
| pushValid | input | 1 | Write strobe from the receiver |
| pushData | input | 8 | Received byte |
| pushParErr | input | 1 | Parity error flag of the received byte |
| pushFrmErr | input | 1 | Framing error flag of the received byte |
| popReq | input | 1 | Host removes the head entry |
| headData | output | 8 | Byte at the head of the queue |
| headParErr | output | 1 | Parity flag of the head entry |
| headFrmErr | output | 1 | Framing flag of the head entry |
| fifoEmpty | output | 1 | Queue holds no entries |
| fifoFull | output | 1 | Queue holds 64 entries |
| fillLevel | output | 7 | Number of stored entries |
| overrun | output | 1 | Sticky flag: a push was lost while the queue was full |
| rxErr | output | 1 | At least one stored entry has an error flag |
| statusWord | output | 16 | Packed parity count (13:8) and framing count (5:0) |

## Verification
The hardest state to reach is the wrap of a count field. The queue must be filled to exactly 64 entries that all carry the same error, so the field reads 0 while rxErr is 1. The stimulus pushes 64 entries with both flags set, checks the wrapped status, and then pushes once more to reach overrun. It then drains the queue, which walks the counts back down through the wrap. A separate sequence lines up a bad entry at the head and pushes another bad one on the same cycle as the pop, to show a count that holds steady.

// File: rtl/rxef_pkg.sv
package rxef_pkg;

  // Per-cycle strobes from control to the datapath.
  typedef struct packed {
    logic push;   // accepted write
    logic pop;    // accepted read
    logic clear;  // synchronous flush
  } rxefStrobe_t;

endpackage

// File: rtl/rxef_ctrl.sv
module rxef_ctrl
  import rxef_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pushReq,
  input  logic                          popReq,
  input  logic                          clearReq,
  output rxefStrobe_t                   strobe,
  output logic [$clog2(DEPTH)-1:0]      wrPtr,
  output logic [$clog2(DEPTH)-1:0]      rdPtr,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          full,
  output logic                          empty,
  output logic                          overrun
);

  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  always_comb begin
    strobe.clear = clearReq;
    strobe.push  = pushReq && !full  && !clearReq;
    strobe.pop   = popReq  && !empty && !clearReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else if (strobe.clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (pushReq && full) overrun <= 1'b1;
    end
  end

  // Occupancy never exceeds capacity.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // A write into a full queue does not raise the level.
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pushReq && !clearReq) |=> (level <= $past(level)) && overrun);

  // A read from an empty queue leaves it empty.
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && popReq && !pushReq && !clearReq) |=> empty);

  // Flush returns to the empty state.
  p_clear_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |=> (empty && !overrun && wrPtr == rdPtr));

endmodule

// File: rtl/rxef_data.sv
module rxef_data
  import rxef_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  rxefStrobe_t                   strobe,
  input  logic [$clog2(DEPTH)-1:0]      wrPtr,
  input  logic [$clog2(DEPTH)-1:0]      rdPtr,
  input  logic [DW-1:0]                 wrData,
  input  logic                          wrPar,
  input  logic                          wrFrm,
  output logic [DW-1:0]                 rdData,
  output logic                          rdPar,
  output logic                          rdFrm,
  output logic [$clog2(DEPTH+1)-1:0]    parCnt,
  output logic [$clog2(DEPTH+1)-1:0]    frmCnt
);

  localparam int CW     = $clog2(DEPTH + 1);
  localparam int NKINDS = 2;  // 0: parity, 1: framing

  logic [DW-1:0]     memData [DEPTH];
  logic [NKINDS-1:0] memFlag [DEPTH];

  logic [NKINDS-1:0] flagIn;
  logic [NKINDS-1:0] flagOut;
  logic [CW-1:0]     errCnt [NKINDS];

  assign flagIn = {wrFrm, wrPar};

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      memData[wrPtr] <= wrData;
      memFlag[wrPtr] <= flagIn;
    end
  end

  assign rdData  = memData[rdPtr];
  assign flagOut = memFlag[rdPtr];
  assign rdPar   = flagOut[0];
  assign rdFrm   = flagOut[1];

  for (genvar g = 0; g < NKINDS; g++) begin : g_cnt
    logic incr, decr;
    assign incr = strobe.push && flagIn[g];
    assign decr = strobe.pop  && flagOut[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            errCnt[g] <= '0;
      else if (strobe.clear) errCnt[g] <= '0;
      else begin
        case ({incr, decr})
          2'b10:   errCnt[g] <= errCnt[g] + CW'(1);
          2'b01:   errCnt[g] <= errCnt[g] - CW'(1);
          default: errCnt[g] <= errCnt[g];
        endcase
      end
    end

    // Count moves by at most one per cycle; equal in and out holds it.
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe.clear && strobe.push && strobe.pop && flagIn[g] && flagOut[g])
        |=> (errCnt[g] == $past(errCnt[g])));

    // Flush zeroes the count.
    p_cnt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.clear |=> (errCnt[g] == '0));
  end

  assign parCnt = errCnt[0];
  assign frmCnt = errCnt[1];

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxef_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fifoClear,
  input  logic                          pushValid,
  input  logic [DW-1:0]                 pushData,
  input  logic                          pushParErr,
  input  logic                          pushFrmErr,
  input  logic                          popReq,
  output logic [DW-1:0]                 headData,
  output logic                          headParErr,
  output logic                          headFrmErr,
  output logic                          fifoEmpty,
  output logic                          fifoFull,
  output logic [$clog2(DEPTH+1)-1:0]    fillLevel,
  output logic                          overrun,
  output logic                          rxErr,
  output logic [15:0]                   statusWord
);

  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int FW = (PW > 6) ? 6 : PW;  // status field width

  rxefStrobe_t    strobe;
  logic [PW-1:0]  wrPtr, rdPtr;
  logic [LW-1:0]  parCnt, frmCnt;

  rxef_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pushReq  (pushValid),
    .popReq   (popReq),
    .clearReq (fifoClear),
    .strobe   (strobe),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .level    (fillLevel),
    .full     (fifoFull),
    .empty    (fifoEmpty),
    .overrun  (overrun)
  );

  rxef_data #(.DEPTH(DEPTH), .DW(DW)) i_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrPtr  (wrPtr),
    .rdPtr  (rdPtr),
    .wrData (pushData),
    .wrPar  (pushParErr),
    .wrFrm  (pushFrmErr),
    .rdData (headData),
    .rdPar  (headParErr),
    .rdFrm  (headFrmErr),
    .parCnt (parCnt),
    .frmCnt (frmCnt)
  );

  // Full-width counts drive the summary flag, so a wrapped field still flags.
  assign rxErr = (parCnt != '0) || (frmCnt != '0);

  always_comb begin
    statusWord         = '0;
    statusWord[8 +: FW] = parCnt[FW-1:0];
    statusWord[0 +: FW] = frmCnt[FW-1:0];
  end

  // Error counts are bounded by occupancy.
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (parCnt <= fillLevel) && (frmCnt <= fillLevel));

  // A flagged entry implies a non-empty queue.
  p_err_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxErr |-> !fifoEmpty);

endmodule

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifoClear = 1'b0, pushValid = 1'b0, popReq = 1'b0;
  logic [7:0]  pushData = '0;
  logic        pushParErr = 1'b0, pushFrmErr = 1'b0;
  logic [7:0]  headData;
  logic        headParErr, headFrmErr, fifoEmpty, fifoFull, overrun, rxErr;
  logic [6:0]  fillLevel;
  logic [15:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit monOn  = 1'b0;

  // Scoreboard: {frm, par, data}
  logic [9:0] expQ [$];
  bit         expOvr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_fifo i_rx_err_fifo (
    .clk(clk), .rst_n(rst_n), .fifoClear(fifoClear),
    .pushValid(pushValid), .pushData(pushData),
    .pushParErr(pushParErr), .pushFrmErr(pushFrmErr), .popReq(popReq),
    .headData(headData), .headParErr(headParErr), .headFrmErr(headFrmErr),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fillLevel(fillLevel),
    .overrun(overrun), .rxErr(rxErr), .statusWord(statusWord)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int cntKind(int bitPos);
    int n = 0;
    foreach (expQ[i]) if (expQ[i][bitPos]) n++;
    return n;
  endfunction

  // Driver: one cycle of stimulus, then the scoreboard follows the edge.
  task automatic step(bit push, logic [7:0] d, bit par, bit frm, bit pop, bit clr);
    bit pushOk;
    @(negedge clk);
    pushValid = push; pushData = d; pushParErr = par; pushFrmErr = frm;
    popReq = pop; fifoClear = clr;
    @(posedge clk);
    if (clr) begin
      expQ.delete();
      expOvr = 1'b0;
    end else begin
      pushOk = push && (expQ.size() < DEPTH);
      if (push && !pushOk) expOvr = 1'b1;
      if (pop && expQ.size() > 0) void'(expQ.pop_front());
      if (pushOk) expQ.push_back({frm, par, d});
    end
    #1;
    pushValid = 1'b0; popReq = 1'b0; fifoClear = 1'b0;
  endtask

  // Monitor: compare outputs with the scoreboard each cycle.
  always @(negedge clk) begin
    if (monOn) begin
      int pc, fc;
      pc = cntKind(8);
      fc = cntKind(9);
      chk("R2 fillLevel", fillLevel, expQ.size());
      chk("R2 fifoEmpty", fifoEmpty, expQ.size() == 0);
      chk("R3 fifoFull", fifoFull, expQ.size() == DEPTH);
      chk("R3 overrun", overrun, expOvr);
      chk("R10 rxErr", rxErr, (pc > 0) || (fc > 0));
      chk("R5 parity field", statusWord[13:8], pc % 64);
      chk("R6 framing field", statusWord[5:0], fc % 64);
      chk("R8 pad bits", {statusWord[15:14], statusWord[7:6]}, 0);
      if (expQ.size() > 0)
        chk("R2 head entry", {headFrmErr, headParErr, headData}, expQ[0]);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset level", fillLevel, 0);
    chk("R1 reset status", statusWord, 0);
    chk("R1 reset flags", {fifoEmpty, rxErr, overrun}, 3'b100);
    rst_n = 1'b1;
    monOn = 1'b1;

    // R2/R5/R6: mixed pattern in and out
    step(1, 8'hA1, 0, 0, 0, 0);
    step(1, 8'hB2, 1, 0, 0, 0);
    step(1, 8'hC3, 0, 1, 0, 0);
    step(1, 8'hD4, 1, 1, 0, 0);
    step(1, 8'hE5, 1, 0, 0, 0);
    @(negedge clk);
    chk("R5 parity count 3", statusWord[13:8], 3);
    chk("R6 framing count 2", statusWord[5:0], 2);
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 0, 1, 0);

    // R4: pop on empty
    step(0, 8'h00, 0, 0, 1, 0);
    @(negedge clk);
    chk("R4 empty pop level", fillLevel, 0);
    chk("R4 empty pop status", {statusWord, rxErr, fifoEmpty}, 18'h1);

    // R7: simultaneous push and pop with errors on both sides
    step(1, 8'h11, 1, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    step(1, 8'h33, 0, 1, 0, 0);
    step(1, 8'h44, 1, 0, 1, 0);
    @(negedge clk);
    chk("R7 parity held", statusWord[13:8], 1);
    chk("R7 level held", fillLevel, 3);
    step(1, 8'h55, 0, 0, 1, 0);
    step(1, 8'h66, 0, 0, 1, 0);
    @(negedge clk);
    chk("R7 framing dropped", statusWord[5:0], 0);

    // R11: flush with a push in the same cycle
    step(1, 8'h77, 1, 1, 0, 1);
    @(negedge clk);
    chk("R11 clear level", fillLevel, 0);
    chk("R11 clear status", statusWord, 0);

    // R9/R3: fill with 64 bad entries, then overrun
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 1, 1, 0, 0);
    @(negedge clk);
    chk("R9 wrapped status", statusWord, 0);
    chk("R9 summary flag", rxErr, 1);
    chk("R3 full", fifoFull, 1);
    step(1, 8'hFF, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3 overrun set", overrun, 1);
    chk("R3 head unchanged", headData, 0);
    step(0, 8'h00, 0, 0, 1, 0);
    @(negedge clk);
    chk("R9 count after one pop", statusWord, 16'h3F3F);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 8'h00, 0, 0, 1, 0);
    @(negedge clk);
    chk("R3 overrun sticky", overrun, 1);

    // R11: flush clears overrun
    step(0, 8'h00, 0, 0, 0, 1);
    @(negedge clk);
    chk("R11 overrun cleared", overrun, 0);

    monOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule